// File: doc/BRIEF.md
# Multi-Clock Serial Shift Unit

This block pairs an 8-bit shift register with a 4-bit transfer counter. One selectable clock source drives both of them. That source can be a software strobe written through the host port, a single-cycle compare-match pulse from a timer, or the edges of an external serial clock pin. Bits arrive on a serial data pin and enter the register from the low end. The top bit of the register drives the serial data output through an output latch. In external-clock modes this latch changes the output on the edge opposite to the one that samples the input.

When the counter wraps, the transfer is complete. The finished byte is copied into a read-only buffer, and a sticky overflow flag is set. The flag can raise an interrupt request. In external-clock modes the counter advances on both serial clock edges, so a byte takes sixteen edges. Software can also stand in for the external pin: it selects a toggle mode and then writes a toggle bit that plays the role of each clock edge.

Host map: address 0 is the data register (read/write). Address 1 is the buffer (read-only). Address 2 is the status register: bit 7 is the overflow flag and bits 3:0 are the counter. Address 3 is the control register: bit 0 is the interrupt enable, bits 2:1 are the clock source, bit 3 is the strobe and bit 4 is the toggle strobe.

Top module: `serial_shift_unit`

## Requirements
- R1: Each shift tick moves the data register left by one bit and loads the serial input into bit 0.
- R2: A host write to address 0 in the same cycle as a shift tick stores the written value, and no shift takes place.
- R3: The clock source field (control bits 2:1) selects the clock. 00 means a control write with bit 3 set clocks both the register and the counter. 01 means each tmr_match_i pulse clocks both. 1x means the external clock, which shifts on its rising edge.
- R4: With source 1x and toggle mode off, sclk_i passes through two synchronizer flops. Both its rising and its falling edges increment the counter. A pin change takes effect on the third rising system clock edge after the change.
- R5: A control write with bit 2 and bit 3 both set turns toggle mode on. Any other control write turns it off. In toggle mode each control write with bit 4 set toggles an internal serial clock level, and that toggle counts as one edge of the selected clock. sclk_i is then ignored.
- R6: sdo_o follows data bit 7 at once when the source is 00 or 01. With source 1x, sdo_o follows bit 7 while the active serial clock level is low and holds its value while that level is high.
- R7: When a count tick arrives at counter value 15 without a host write to address 2, the counter wraps to 0 and the overflow flag is set. Writing address 2 with bit 7 set clears the flag.
- R8: irq_o is high exactly when the overflow flag and the enable (control bit 0) are both set.
- R9: On each wrap, the buffer at address 1 takes the data register value that results from that same cycle.
- R10: The counter can be read and written at address 2 bits 3:0. Control bits 3 and 4 always read as zero. Every register resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| sclk_i | input | 1 | External serial clock |
| sdi_i | input | 1 | Serial data in |
| tmr_match_i | input | 1 | Timer compare-match pulse |
| sdo_o | output | 1 | Serial data out through the output latch |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Host writes, strobes and timer pulses are applied in one cycle and show up in the registers on the next rising edge. An sclk_i change shows up only on the third rising edge, because the synchronizer and the edge detector lie in its path. The output latch is closed in the cycle that follows a rising serial edge, so sdo_o keeps the old top bit until the falling edge is seen. A behavioural model in the bench carries the same register latencies. It is compared 2 ns after every rising edge, and directed checks read results back only after the pipeline has settled.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_BUF  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_CTRL = 2'd3
  } ssu_addr_e;

  typedef enum logic [1:0] {
    SRC_SOFT = 2'b00,
    SRC_TMR  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_EXTB = 2'b11
  } ssu_src_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_SRC_LO  = 1;
  localparam int CTL_STB_BIT = 3;
  localparam int CTL_TGL_BIT = 4;
  localparam int STA_FLG_BIT = 7;
endpackage

// File: rtl/ssu_clk_gen.sv
module ssu_clk_gen
  import ssu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic [1:0] src_i,
  input  logic       tgl_mode_i,
  input  logic       strobe_i,
  input  logic       toggle_i,
  input  logic       tmr_i,
  output logic       shift_tick_o,
  output logic       count_tick_o,
  output logic       transparent_o
);
  logic sync1_q, sync2_q, prev_q, vclk_q;
  logic vclk_d;
  logic ext, tgl_ev, rise, fall, lvl;

  always_comb begin
    ext    = src_i[1];
    tgl_ev = toggle_i & ext & tgl_mode_i;
    if (tgl_mode_i) begin
      rise = tgl_ev & ~vclk_q;
      fall = tgl_ev & vclk_q;
    end else begin
      rise = ext & sync2_q & ~prev_q;
      fall = ext & ~sync2_q & prev_q;
    end
    vclk_d = tgl_ev ? ~vclk_q : vclk_q;
    unique case (src_i)
      SRC_SOFT: begin shift_tick_o = strobe_i; count_tick_o = strobe_i; end
      SRC_TMR:  begin shift_tick_o = tmr_i;    count_tick_o = tmr_i;    end
      default:  begin shift_tick_o = rise;     count_tick_o = rise | fall; end
    endcase
    lvl           = tgl_mode_i ? vclk_q : sync2_q;
    transparent_o = ~ext | ~lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      vclk_q  <= 1'b0;
    end else begin
      sync1_q <= sclk_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      vclk_q  <= vclk_d;
    end
  end

  // R4: one serial edge at most per cycle
  a_r4_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  // R5: a toggle event flips the virtual level
  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_ev |=> (vclk_q != $past(vclk_q)));
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          clr_flag_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    wrap_o = tick_i & ~load_i & (cnt_q == CNT_MAX);
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    if (wrap_o)          flag_d = 1'b1;
    else if (clr_flag_i) flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R7: wrap from the top value lands on zero with the flag set
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q == CNT_MAX) |=> (cnt_q == '0 && flag_q));
  // R7: clear without a wrap drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag_i && !wrap_o) |=> !flag_q);
  // R10: host load takes priority over counting
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/ssu_shreg.sv
module ssu_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wval_i,
  input  logic          din_i,
  input  logic          shift_i,
  input  logic          wrap_i,
  input  logic          transparent_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] buf_o,
  output logic          dout_o
);
  logic [DW-1:0] data_q, data_d, buf_q, buf_d;
  logic          held_q, held_d;

  always_comb begin
    if (wr_i)         data_d = wval_i;
    else if (shift_i) data_d = {data_q[DW-2:0], din_i};
    else              data_d = data_q;
    buf_d  = wrap_i ? data_d : buf_q;
    held_d = transparent_i ? data_q[DW-1] : held_q;
    dout_o = transparent_i ? data_q[DW-1] : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      buf_q  <= '0;
      held_q <= 1'b0;
    end else begin
      data_q <= data_d;
      buf_q  <= buf_d;
      held_q <= held_d;
    end
  end

  assign data_o = data_q;
  assign buf_o  = buf_q;

  // R1: shift moves left and takes the serial bit
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !wr_i) |=> data_q == {$past(data_q[DW-2:0]), $past(din_i)});
  // R2: host write wins over a shift
  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> data_q == $past(wval_i));
  // R6: closed latch keeps the output still
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!transparent_i && $past(!transparent_i)) |-> $stable(dout_o));
  // R9: buffer matches the register after a wrap
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> buf_q == data_q);
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          tmr_match_i,
  output logic          sdo_o,
  output logic          irq_o
);
  localparam int PADW = STA_FLG_BIT - CW;

  logic       rst_s1_q, rst_s2_q, rst_int_n;
  logic       en_q, en_d, tgl_q, tgl_d;
  logic [1:0] src_q, src_d;
  logic       wr_data, wr_stat, wr_ctrl, strobe, toggle;
  logic       shift_tick, count_tick, transparent, wrap, flag;
  logic [CW-1:0] cnt;
  logic [DW-1:0] data, bufv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  always_comb begin
    wr_data = host_wr && (host_addr == ADDR_DATA);
    wr_stat = host_wr && (host_addr == ADDR_STAT);
    wr_ctrl = host_wr && (host_addr == ADDR_CTRL);
    strobe  = wr_ctrl && host_wdata[CTL_STB_BIT];
    toggle  = wr_ctrl && host_wdata[CTL_TGL_BIT];
    en_d    = wr_ctrl ? host_wdata[CTL_EN_BIT] : en_q;
    src_d   = wr_ctrl ? host_wdata[CTL_SRC_LO +: 2] : src_q;
    tgl_d   = wr_ctrl ? (host_wdata[CTL_STB_BIT] & host_wdata[CTL_SRC_LO + 1]) : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= 1'b0;
      src_q <= SRC_SOFT;
      tgl_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      src_q <= src_d;
      tgl_q <= tgl_d;
    end
  end

  ssu_clk_gen u_clk (
    .clk(clk), .rst_n(rst_int_n), .sclk_i(sclk_i), .src_i(src_q),
    .tgl_mode_i(tgl_q), .strobe_i(strobe), .toggle_i(toggle), .tmr_i(tmr_match_i),
    .shift_tick_o(shift_tick), .count_tick_o(count_tick), .transparent_o(transparent)
  );

  ssu_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load_i(wr_stat), .load_val_i(host_wdata[CW-1:0]),
    .clr_flag_i(wr_stat && host_wdata[STA_FLG_BIT]), .tick_i(count_tick),
    .cnt_o(cnt), .flag_o(flag), .wrap_o(wrap)
  );

  ssu_shreg #(.DW(DW)) u_sr (
    .clk(clk), .rst_n(rst_int_n), .wr_i(wr_data), .wval_i(host_wdata), .din_i(sdi_i),
    .shift_i(shift_tick), .wrap_i(wrap), .transparent_i(transparent),
    .data_o(data), .buf_o(bufv), .dout_o(sdo_o)
  );

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      ADDR_DATA: host_rdata = data;
      ADDR_BUF:  host_rdata = bufv;
      ADDR_STAT: host_rdata = {flag, {PADW{1'b0}}, cnt};
      default: begin
        host_rdata[CTL_EN_BIT]       = en_q;
        host_rdata[CTL_SRC_LO +: 2]  = src_q;
      end
    endcase
  end

  assign irq_o = flag & en_q;

  // R8: no request without the enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_q |-> !irq_o);
  // R10: strobe fields never read back as one
  a_r10_strobe_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_addr == ADDR_CTRL) |-> (host_rdata[CTL_STB_BIT] == 1'b0 && host_rdata[CTL_TGL_BIT] == 1'b0));
endmodule

// File: tb/serial_shift_unit_tb.sv
`timescale 1ns/1ps
module serial_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       sclk_i = 1'b0, sdi_i = 1'b0, tmr_match_i = 1'b0;
  logic       sdo_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk_i(sclk_i),
    .sdi_i(sdi_i), .tmr_match_i(tmr_match_i), .sdo_o(sdo_o), .irq_o(irq_o)
  );

  // behavioural reference state
  int m_data, m_buf, m_cnt, m_src;
  bit m_flag, m_en, m_tgl, m_vclk, m_held, m_s1, m_s2, m_d;

  function automatic bit m_transp();
    bit lvl;
    lvl = m_tgl ? m_vclk : m_s2;
    return (m_src < 2) || !lvl;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_data;
      1: return m_buf;
      2: return (m_flag ? 128 : 0) + m_cnt;
      default: return m_src * 2 + (m_en ? 1 : 0);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_buf = 0; m_cnt = 0; m_src = 0;
      m_flag = 0; m_en = 0; m_tgl = 0; m_vclk = 0; m_held = 0;
      m_s1 = 0; m_s2 = 0; m_d = 0;
    end else begin
      bit wd, ws, wc, stb, tog, rise, fall, sh, ct, wrapv, tp;
      int nd;
      wd  = host_wr && host_addr == 0;
      ws  = host_wr && host_addr == 2;
      wc  = host_wr && host_addr == 3;
      stb = wc && host_wdata[3];
      tog = wc && host_wdata[4] && m_src >= 2 && m_tgl;
      if (m_tgl) begin rise = tog && !m_vclk; fall = tog && m_vclk; end
      else begin rise = m_src >= 2 && m_s2 && !m_d; fall = m_src >= 2 && !m_s2 && m_d; end
      if (m_src == 0) begin sh = stb; ct = stb; end
      else if (m_src == 1) begin sh = tmr_match_i; ct = tmr_match_i; end
      else begin sh = rise; ct = rise || fall; end
      tp = m_transp();
      if (wd) nd = host_wdata;
      else if (sh) nd = ((m_data * 2) % 256) + (sdi_i ? 1 : 0);
      else nd = m_data;
      wrapv = ct && !ws && m_cnt == 15;
      if (tp) m_held = m_data >= 128;
      if (wrapv) m_buf = nd;
      m_data = nd;
      if (ws) m_cnt = host_wdata & 15;
      else if (ct) m_cnt = (m_cnt + 1) % 16;
      if (wrapv) m_flag = 1;
      else if (ws && host_wdata[7]) m_flag = 0;
      if (tog) m_vclk = !m_vclk;
      if (wc) begin
        m_en = host_wdata[0]; m_src = (host_wdata >> 1) & 3;
        m_tgl = host_wdata[3] && host_wdata[2];
      end
      m_d = m_s2; m_s2 = m_s1; m_s1 = sclk_i;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bool_cmp: begin
        chk("R6 sdo", sdo_o, m_transp() ? (m_data >= 128) : m_held);
        chk("R8 irq", irq_o, m_flag && m_en);
        chk("R10 rdata", host_rdata, m_read(host_addr));
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); host_addr = a[1:0]; host_wdata = d[7:0]; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    @(negedge clk); host_addr = a[1:0]; #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int b;
    idle(3); rst_n = 1'b1; idle(4);
    // R10 reset state
    for (int a = 0; a < 4; a++) rd_chk("R10 reset", a, 0);

    // R3/R1 software strobe: shift in 0x5A
    b = 8'h5A;
    for (int i = 7; i >= 0; i--) begin sdi_i = b[i]; wr(3, 8'h08); end
    rd_chk("R1 strobe shift", 0, 8'h5A);
    rd_chk("R3 strobe count", 2, 8);
    rd_chk("R10 strobe bits read zero", 3, 0);

    // R3/R2 timer source, collision with data write
    wr(3, 8'h03);
    @(negedge clk); sdi_i = 1'b1; tmr_match_i = 1'b1; host_addr = 0; host_wdata = 8'h81; host_wr = 1'b1;
    @(negedge clk); tmr_match_i = 1'b0; host_wr = 1'b0;
    rd_chk("R2 write wins", 0, 8'h81);
    rd_chk("R3 timer count", 2, 9);

    // R7/R8/R9 wrap with timer pulses
    wr(2, 8'h0E);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); sdi_i = 1'b0; tmr_match_i = 1'b1;
      @(negedge clk); tmr_match_i = 1'b0;
    end
    rd_chk("R7 wrap flag", 2, 8'h80);
    rd_chk("R9 buffer", 1, 8'h04);
    chk("R8 irq high", irq_o, 1);
    wr(2, 8'h80);
    rd_chk("R7 w1c", 2, 0);

    // R4/R6 external clock, byte 0x3C
    wr(3, 8'h05);
    b = 8'h3C;
    for (int i = 7; i >= 0; i--) begin
      sdi_i = b[i]; idle(3); sclk_i = 1'b1; idle(4); sclk_i = 1'b0; idle(1);
    end
    idle(6);
    rd_chk("R4 both edges wrap", 2, 8'h80);
    rd_chk("R9 external byte", 1, 8'h3C);
    wr(2, 8'h80);

    // R5 toggle mode, byte 0xC3
    wr(3, 8'h0D);
    b = 8'hC3;
    for (int i = 7; i >= 0; i--) begin
      sdi_i = b[i]; wr(3, 8'h1D); idle(1); wr(3, 8'h1D); idle(1);
    end
    rd_chk("R5 toggle byte", 1, 8'hC3);
    rd_chk("R5 toggle wrap", 2, 8'h80);
    sclk_i = 1'b1; idle(6); sclk_i = 1'b0; idle(6);
    rd_chk("R5 pin ignored", 2, 8'h80);
    rd_chk("R10 ctrl readback", 3, 8'h05);
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule